// File: doc/BRIEF.md
# Radio Receive Frame Parser

This block drains received frames from a radio transceiver's receive FIFO. It watches two status flags from the radio: a not-empty flag and a threshold flag. When both are high it opens an SPI read session through a byte-level SPI engine and pulls out one fixed-size frame: a length byte, a source address, a destination address, four payload bytes and two check bytes. It decides whether the frame is meant for this node and whether the radio reported a good CRC. Payload bytes go into a downstream session buffer as they arrive. At the end of the frame the block pulses commit or discard for that buffer.

The same flags also signal a FIFO fault. If the not-empty flag is low while the threshold flag is high, the FIFO has overflowed or underflowed. The block then ends any open session and issues the receive-flush command twice, each command in its own one-byte session, before it goes back to waiting for data.

The SPI engine requests each outgoing byte with a one-cycle `spiReq` pulse. The parser answers in the same cycle through `spiTxValid`/`spiTxByte`, and an answer with `spiTxValid` low closes the session. For every byte that was shifted out, the engine returns the byte it clocked in as a one-cycle `spiRxValid` pulse. That pulse always comes before the next request.

Top module: `rfrx_frame_parser`

## Requirements
- R1: After reset, no buffer strobe (`bufWrite`, `bufCommit`, `bufDiscard`) is high, and a request is answered with `spiTxValid` low as long as the flags show neither data nor a fault.
- R2: With both flags high, the next session sends the read command 0x7F, then exactly nine 0x00 filler bytes, and then answers the following request with `spiTxValid` low. The read command has bit 7 = 0 (register), bit 6 = 1 (read) and bits 5:0 = 0x3F. `spiTxValid` is never high without `spiReq`.
- R3: The first returned byte is radio status and is ignored. If the second returned byte (the length) is not 0x08, the request that follows is refused, so the session ends after 2 bytes. No payload is written and the flush pair follows.
- R4: The returned bytes are, in order: length, source address, destination address, payload bytes 0 to 3, first check byte, second check byte. For an accepted frame, the four payload bytes are written in arrival order on `bufData`, with one `bufWrite` cycle each, tagged with the frame's source on `bufSrc` and destination on `bufDst`.
- R5: For an accepted frame, exactly one of `bufCommit` and `bufDiscard` pulses, in the cycle after the second check byte is returned. It is commit if bit 7 of that byte is 1 and discard if bit 7 is 0.
- R6: A frame whose destination is 0xFF is accepted, whatever its source and whatever the configured addresses.
- R7: When `remoteAddr` is 0xFF, a frame is accepted if its destination equals `localAddr`, whatever its source.
- R8: Otherwise a frame is accepted only if its source equals `remoteAddr` and its destination equals `localAddr`. A rejected frame is still read to the end but produces no write, commit or discard.
- R9: A fault (not-empty low, threshold high) seen while idle produces two sessions of one byte each, both 0x08, and then a return to idle.
- R10: A fault during a read session refuses the next request. Then `bufDiscard` pulses once if payload of that frame was already written (and not at all if none was), and the two flush sessions follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fifoNotEmpty | input | 1 | Radio receive FIFO holds at least one byte |
| fifoAboveThresh | input | 1 | Radio FIFO threshold reached or frame complete |
| localAddr | input | 8 | This node's address |
| remoteAddr | input | 8 | Expected peer address; 0xFF selects broadcast mode |
| spiReq | input | 1 | SPI engine asks for the next byte to send |
| spiTxValid | output | 1 | A byte is supplied; low closes the session |
| spiTxByte | output | 8 | Byte to send |
| spiRxValid | input | 1 | A received byte is presented |
| spiRxByte | input | 8 | Received byte |
| bufWrite | output | 1 | Write one payload byte into the session buffer |
| bufData | output | 8 | Payload byte |
| bufSrc | output | 8 | Source address tag for the payload |
| bufDst | output | 8 | Destination address tag for the payload |
| bufCommit | output | 1 | Keep the payload written in this session |
| bufDiscard | output | 1 | Drop the payload written in this session |

## Verification
The hardest case to reach is a fault that arrives in the middle of a read session, after some payload has already gone into the buffer. It calls for a discard of a partial frame, followed by the flush pair. The bench's SPI engine model can raise the fault flags right after a chosen byte index has been returned. It does so once after the second payload byte, where a discard is expected, and once after the source byte, where no discard is expected. Random frames cover the three address acceptance modes together with good and bad check bytes.

// File: rtl/rfrx_pkg.sv
package rfrx_pkg;
  localparam int BYTE_W = 8;

  typedef enum logic [2:0] {
    S_IDLE, S_CMD, S_DATA, S_FLA, S_FLAE, S_FLB, S_FLBE
  } rxState_t;

  typedef struct packed {
    logic clrFrame;
    logic capSrc;
    logic capDst;
    logic wrPay;
    logic finish;
    logic abort;
  } dpCtl_t;
endpackage

// File: rtl/rfrx_ctrl.sv
module rfrx_ctrl
  import rfrx_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 4,
  parameter logic [5:0] RXFIFO_ADDR = 6'h3F,
  parameter logic [7:0] CMD_FLUSH = 8'h08
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        fifoNotEmpty,
  input  logic        fifoAboveThresh,
  input  logic        spiReq,
  input  logic        spiRxValid,
  input  logic [7:0]  spiRxByte,
  output logic        spiTxValid,
  output logic [7:0]  spiTxByte,
  output dpCtl_t      ctl
);
  localparam int FRAME_LEN = 2 + PAYLOAD_BYTES + 2;
  localparam int DUMMY_CNT = FRAME_LEN + 1;
  localparam int IDX_W = $clog2(DUMMY_CNT + 2);
  localparam logic [IDX_W-1:0] IDX_LEN  = IDX_W'(1);
  localparam logic [IDX_W-1:0] IDX_SRC  = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_DST  = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_PAY0 = IDX_W'(4);
  localparam logic [IDX_W-1:0] IDX_PAYE = IDX_W'(4 + PAYLOAD_BYTES);
  localparam logic [IDX_W-1:0] IDX_CRC1 = IDX_W'(4 + PAYLOAD_BYTES + 1);
  localparam logic [IDX_W-1:0] DUMMY_LIM = IDX_W'(DUMMY_CNT);
  localparam logic [7:0] READ_CMD = {1'b0, 1'b1, RXFIFO_ADDR};
  localparam logic [7:0] LEN_VAL = 8'(FRAME_LEN);

  rxState_t state, nextState;
  logic [IDX_W-1:0] sentCnt, rxCnt;
  logic errSeen, lenBad;
  logic errNow, startNow, frameBad;

  assign errNow   = !fifoNotEmpty && fifoAboveThresh;
  assign startNow = fifoNotEmpty && fifoAboveThresh;
  assign frameBad = errSeen || errNow || lenBad;

  always_comb begin
    nextState  = state;
    spiTxValid = 1'b0;
    spiTxByte  = '0;
    ctl        = '0;
    case (state)
      S_IDLE: begin
        if (errNow) nextState = S_FLA;
        else if (startNow) nextState = S_CMD;
      end
      S_CMD: begin
        if (errNow) nextState = S_FLA;
        else if (spiReq) begin
          spiTxValid   = 1'b1;
          spiTxByte    = READ_CMD;
          ctl.clrFrame = 1'b1;
          nextState    = S_DATA;
        end
      end
      S_DATA: begin
        if (spiReq) begin
          if (frameBad) begin
            ctl.abort = 1'b1;
            nextState = S_FLA;
          end else if (sentCnt < DUMMY_LIM) begin
            spiTxValid = 1'b1;
          end else begin
            nextState = S_IDLE;
          end
        end
        if (spiRxValid && !errSeen && !lenBad) begin
          ctl.capSrc = (rxCnt == IDX_SRC);
          ctl.capDst = (rxCnt == IDX_DST);
          ctl.wrPay  = (rxCnt >= IDX_PAY0) && (rxCnt < IDX_PAYE);
          ctl.finish = (rxCnt == IDX_CRC1);
        end
      end
      S_FLA, S_FLB: begin
        if (spiReq) begin
          spiTxValid = 1'b1;
          spiTxByte  = CMD_FLUSH;
          nextState  = (state == S_FLA) ? S_FLAE : S_FLBE;
        end
      end
      S_FLAE: if (spiReq) nextState = S_FLB;
      S_FLBE: if (spiReq) nextState = S_IDLE;
      default: nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state   <= S_IDLE;
      sentCnt <= '0;
      rxCnt   <= '0;
      errSeen <= 1'b0;
      lenBad  <= 1'b0;
    end else begin
      state <= nextState;
      if (ctl.clrFrame) begin
        sentCnt <= '0;
        rxCnt   <= '0;
        errSeen <= 1'b0;
        lenBad  <= 1'b0;
      end else if (state == S_DATA) begin
        if (spiReq && spiTxValid) sentCnt <= sentCnt + 1'b1;
        if (spiRxValid) begin
          rxCnt <= rxCnt + 1'b1;
          if (rxCnt == IDX_LEN && spiRxByte != LEN_VAL) lenBad <= 1'b1;
        end
        if (errNow) errSeen <= 1'b1;
      end
    end
  end

  assert_tx_on_req_R2: assert property (@(posedge clk) disable iff (rst)
    spiTxValid |-> spiReq);
  assert_dummy_bound_R2: assert property (@(posedge clk) disable iff (rst)
    sentCnt <= DUMMY_LIM);
  assert_len_refuse_R3: assert property (@(posedge clk) disable iff (rst)
    (state == S_DATA && lenBad && spiReq) |-> !spiTxValid);
  assert_idle_fault_R9: assert property (@(posedge clk) disable iff (rst)
    (state == S_IDLE && errNow) |=> (state == S_FLA));
  assert_fault_refuse_R10: assert property (@(posedge clk) disable iff (rst)
    (state == S_DATA && errSeen && spiReq) |-> (!spiTxValid && ctl.abort));
endmodule

// File: rtl/rfrx_datapath.sv
module rfrx_datapath
  import rfrx_pkg::*;
#(
  parameter logic [7:0] BCAST_ADDR = 8'hFF
) (
  input  logic        clk,
  input  logic        rst,
  input  dpCtl_t      ctl,
  input  logic [7:0]  rxByte,
  input  logic [7:0]  localAddr,
  input  logic [7:0]  remoteAddr,
  output logic        bufWrite,
  output logic [7:0]  bufData,
  output logic [7:0]  bufSrc,
  output logic [7:0]  bufDst,
  output logic        bufCommit,
  output logic        bufDiscard
);
  logic [7:0] srcReg, dstReg;
  logic accepted, wroteAny, acceptNow;

  always_comb begin
    if (rxByte == BCAST_ADDR)
      acceptNow = 1'b1;
    else if (remoteAddr == BCAST_ADDR)
      acceptNow = (rxByte == localAddr);
    else
      acceptNow = (srcReg == remoteAddr) && (rxByte == localAddr);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      srcReg     <= '0;
      dstReg     <= '0;
      accepted   <= 1'b0;
      wroteAny   <= 1'b0;
      bufWrite   <= 1'b0;
      bufData    <= '0;
      bufCommit  <= 1'b0;
      bufDiscard <= 1'b0;
    end else begin
      bufWrite   <= 1'b0;
      bufCommit  <= 1'b0;
      bufDiscard <= 1'b0;
      if (ctl.clrFrame) begin
        accepted <= 1'b0;
        wroteAny <= 1'b0;
      end
      if (ctl.capSrc) srcReg <= rxByte;
      if (ctl.capDst) begin
        dstReg   <= rxByte;
        accepted <= acceptNow;
      end
      if (ctl.wrPay && accepted) begin
        bufWrite <= 1'b1;
        bufData  <= rxByte;
        wroteAny <= 1'b1;
      end
      if (ctl.finish) begin
        bufCommit  <= accepted && rxByte[7];
        bufDiscard <= accepted && !rxByte[7];
        wroteAny   <= 1'b0;
      end
      if (ctl.abort) begin
        bufDiscard <= wroteAny;
        wroteAny   <= 1'b0;
      end
    end
  end

  assign bufSrc = srcReg;
  assign bufDst = dstReg;

  assert_end_excl_R5: assert property (@(posedge clk) disable iff (rst)
    !(bufCommit && bufDiscard));
  assert_write_accepted_R8: assert property (@(posedge clk) disable iff (rst)
    bufWrite |-> accepted);
  assert_commit_has_data_R4: assert property (@(posedge clk) disable iff (rst)
    bufCommit |-> $past(wroteAny));
endmodule

// File: rtl/rfrx_frame_parser.sv
module rfrx_frame_parser
  import rfrx_pkg::*;
#(
  parameter int PAYLOAD_BYTES = 4,
  parameter logic [5:0] RXFIFO_ADDR = 6'h3F,
  parameter logic [7:0] CMD_FLUSH = 8'h08,
  parameter logic [7:0] BCAST_ADDR = 8'hFF
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fifoNotEmpty,
  input  logic       fifoAboveThresh,
  input  logic [7:0] localAddr,
  input  logic [7:0] remoteAddr,
  input  logic       spiReq,
  output logic       spiTxValid,
  output logic [7:0] spiTxByte,
  input  logic       spiRxValid,
  input  logic [7:0] spiRxByte,
  output logic       bufWrite,
  output logic [7:0] bufData,
  output logic [7:0] bufSrc,
  output logic [7:0] bufDst,
  output logic       bufCommit,
  output logic       bufDiscard
);
  dpCtl_t ctl;

  rfrx_ctrl #(
    .PAYLOAD_BYTES(PAYLOAD_BYTES),
    .RXFIFO_ADDR(RXFIFO_ADDR),
    .CMD_FLUSH(CMD_FLUSH)
  ) uCtrl (
    .clk(clk), .rst(rst),
    .fifoNotEmpty(fifoNotEmpty), .fifoAboveThresh(fifoAboveThresh),
    .spiReq(spiReq), .spiRxValid(spiRxValid), .spiRxByte(spiRxByte),
    .spiTxValid(spiTxValid), .spiTxByte(spiTxByte), .ctl(ctl)
  );

  rfrx_datapath #(.BCAST_ADDR(BCAST_ADDR)) uDp (
    .clk(clk), .rst(rst), .ctl(ctl), .rxByte(spiRxByte),
    .localAddr(localAddr), .remoteAddr(remoteAddr),
    .bufWrite(bufWrite), .bufData(bufData), .bufSrc(bufSrc), .bufDst(bufDst),
    .bufCommit(bufCommit), .bufDiscard(bufDiscard)
  );
endmodule

// File: tb/tb_rfrx_frame_parser.sv
`timescale 1ns/1ps
module tb_rfrx_frame_parser;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic fifoNotEmpty = 1'b0, fifoAboveThresh = 1'b0;
  logic [7:0] localAddr = 8'h11, remoteAddr = 8'h22;
  logic spiReq = 1'b0, spiRxValid = 1'b0;
  logic [7:0] spiRxByte = 8'h00;
  logic spiTxValid, bufWrite, bufCommit, bufDiscard;
  logic [7:0] spiTxByte, bufData, bufSrc, bufDst;

  rfrx_frame_parser dut (.*);

  always #4 clk = ~clk;

  int checks = 0, errors = 0;
  bit done = 1'b0;
  logic [7:0] frm [0:9];
  logic [7:0] sent [0:39];
  logic [7:0] wrData [0:63];
  logic [7:0] wrSrc [0:63];
  logic [7:0] wrDst [0:63];
  int wrN = 0, comN = 0, disN = 0;

  always @(negedge clk) begin
    if (!rst) begin
      if (bufWrite && wrN < 64) begin
        wrData[wrN] = bufData; wrSrc[wrN] = bufSrc; wrDst[wrN] = bufDst; wrN++;
      end
      if (bufCommit) comN++;
      if (bufDiscard) disN++;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic bit expAccept(input logic [7:0] s, input logic [7:0] d,
                                   input logic [7:0] loc, input logic [7:0] rem);
    if (d == 8'hFF) return 1'b1;
    if (rem == 8'hFF) return d == loc;
    return (s == rem) && (d == loc);
  endfunction

  task automatic runSession(output int n, input int errAt);
    bit v;
    logic [7:0] b;
    n = 0;
    for (int g = 0; g < 40; g++) begin
      @(posedge clk); #1 spiReq = 1'b1;
      @(negedge clk); v = spiTxValid; b = spiTxByte;
      @(posedge clk); #1 spiReq = 1'b0;
      if (!v) break;
      sent[n] = b;
      if (n == 0) begin fifoNotEmpty = 1'b0; fifoAboveThresh = 1'b0; end
      @(posedge clk); #1 spiRxValid = 1'b1; spiRxByte = (n < 10) ? frm[n] : 8'h00;
      @(posedge clk); #1 spiRxValid = 1'b0;
      if (n == errAt) begin fifoNotEmpty = 1'b0; fifoAboveThresh = 1'b1; end
      n++;
    end
  endtask

  task automatic nextSession(output int n, input int errAt);
    n = 0;
    for (int t = 0; t < 30; t++) begin
      runSession(n, errAt);
      if (n > 0) return;
    end
  endtask

  task automatic loadFrame(input logic [7:0] len, input logic [7:0] s, input logic [7:0] d,
                           input logic [31:0] pay, input logic [7:0] crc1);
    frm[0] = 8'h42; frm[1] = len; frm[2] = s; frm[3] = d;
    frm[4] = pay[31:24]; frm[5] = pay[23:16]; frm[6] = pay[15:8]; frm[7] = pay[7:0];
    frm[8] = 8'h5A; frm[9] = crc1;
    wrN = 0; comN = 0; disN = 0;
  endtask

  task automatic expectFlushPair(input string tag);
    int n;
    for (int k = 0; k < 2; k++) begin
      nextSession(n, -1);
      check(n == 1 && sent[0] == 8'h08, tag, (n << 8) | sent[0], 'h108);
    end
    nextSession(n, -1);
    check(n == 0, {tag, " idle after flush"}, n, 0);
  endtask

  task automatic goodFrame(input logic [7:0] s, input logic [7:0] d, input logic [31:0] pay,
                           input bit crcOk, input string tag);
    int n;
    bit acc;
    bit fillOk;
    acc = expAccept(s, d, localAddr, remoteAddr);
    loadFrame(8'h08, s, d, pay, crcOk ? 8'h80 | 8'($urandom_range(0, 127)) : 8'($urandom_range(0, 127)));
    fifoNotEmpty = 1'b1; fifoAboveThresh = 1'b1;
    nextSession(n, -1);
    repeat (3) @(posedge clk);
    fillOk = 1'b1;
    for (int k = 1; k < 10; k++) if (sent[k] != 8'h00) fillOk = 1'b0;
    check(n == 10 && sent[0] == 8'h7F && fillOk, {tag, " R2 read session"}, n, 10);
    check(wrN == (acc ? 4 : 0), {tag, " R4/R8 write count"}, wrN, acc ? 4 : 0);
    if (acc && wrN == 4) begin
      for (int k = 0; k < 4; k++)
        check(wrData[k] == frm[4+k] && wrSrc[k] == s && wrDst[k] == d,
              {tag, " R4 payload"}, wrData[k], frm[4+k]);
    end
    check(comN == ((acc && crcOk) ? 1 : 0), {tag, " R5 commit"}, comN, (acc && crcOk) ? 1 : 0);
    check(disN == ((acc && !crcOk) ? 1 : 0), {tag, " R5 discard"}, disN, (acc && !crcOk) ? 1 : 0);
  endtask

  initial begin
    int n;
    logic [7:0] pool [0:3];
    void'($urandom(32'd7));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    check(!bufWrite && !bufCommit && !bufDiscard, "R1 reset strobes", bufWrite, 0);
    for (int k = 0; k < 10; k++) frm[k] = 8'h00;
    nextSession(n, -1);
    check(n == 0, "R1 idle refuses requests", n, 0);

    localAddr = 8'h11; remoteAddr = 8'h22;
    goodFrame(8'h22, 8'h11, 32'hDEADBEEF, 1'b1, "R8 match");
    goodFrame(8'h22, 8'h11, 32'h01020304, 1'b0, "R5 bad crc");
    goodFrame(8'h33, 8'h11, 32'hA5A5A5A5, 1'b1, "R8 wrong src");
    goodFrame(8'h22, 8'h44, 32'hA5A5A5A5, 1'b1, "R8 wrong dst");
    goodFrame(8'h77, 8'hFF, 32'hCAFEF00D, 1'b1, "R6 broadcast");
    remoteAddr = 8'hFF;
    goodFrame(8'h99, 8'h11, 32'h13572468, 1'b1, "R7 bcast mode");
    goodFrame(8'h99, 8'h12, 32'h13572468, 1'b1, "R7 bcast mode miss");

    remoteAddr = 8'h22;
    loadFrame(8'h09, 8'h22, 8'h11, 32'h11223344, 8'h80);
    fifoNotEmpty = 1'b1; fifoAboveThresh = 1'b1;
    nextSession(n, -1);
    check(n == 2, "R3 bad length session bytes", n, 2);
    expectFlushPair("R3 flush");
    check(wrN == 0 && comN == 0 && disN == 0, "R3 no strobes", wrN + comN + disN, 0);

    loadFrame(8'h08, 8'h22, 8'h11, 32'h11223344, 8'h80);
    fifoNotEmpty = 1'b0; fifoAboveThresh = 1'b1;
    expectFlushPair("R9 idle fault");

    loadFrame(8'h08, 8'h22, 8'h11, 32'h55667788, 8'h80);
    fifoNotEmpty = 1'b1; fifoAboveThresh = 1'b1;
    nextSession(n, 5);
    check(n == 6, "R10 fault mid payload bytes", n, 6);
    expectFlushPair("R10 flush a");
    check(wrN == 2 && disN == 1 && comN == 0, "R10 partial discard", (wrN << 4) | disN, 'h21);

    loadFrame(8'h08, 8'h22, 8'h11, 32'h55667788, 8'h80);
    fifoNotEmpty = 1'b1; fifoAboveThresh = 1'b1;
    nextSession(n, 2);
    check(n == 3, "R10 fault before payload bytes", n, 3);
    expectFlushPair("R10 flush b");
    check(wrN == 0 && disN == 0 && comN == 0, "R10 no discard", wrN + disN + comN, 0);

    pool[0] = 8'h11; pool[1] = 8'h22; pool[2] = 8'hFF; pool[3] = 8'h5C;
    for (int it = 0; it < 40; it++) begin
      localAddr  = (it % 2) ? 8'h11 : 8'h22;
      remoteAddr = pool[$urandom_range(0, 3)];
      goodFrame(pool[$urandom_range(0, 3)], pool[$urandom_range(0, 3)], $urandom(),
                1'($urandom_range(0, 1)), "R6/R7/R8 random");
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule